// File: doc/BRIEF.md
# PCI Configuration IDSEL Decoder with Device Hiding

This block sits in a host-to-PCI bridge. For every Type 0 configuration cycle it turns the target device number into one IDSEL line in the upper address field, AD[31:16]. External device N uses AD[16+N] as its IDSEL. An integrated device at device number 8 uses AD[24]. For that integrated device the block also raises a decode-hit signal, which lets the bridge claim the cycle internally.

Software controls a 16-bit hide register. A set bit for an external device (0 to 5) keeps that device's IDSEL low. The device then never answers configuration cycles and looks absent. The bit for the integrated device works differently. It removes only the bridge's internal decode, and the cycle on the bus is unchanged.

The hide register is captured when a configuration cycle starts. A write that lands during a cycle therefore takes effect only from the next cycle. When no target claims a Type 0 cycle, the block flags a master abort, and the bridge then returns all ones on reads.

Top module: `cfg_idsel_gate`

## Requirements
- R1: After reset the hide register reads 0x0000, no cycle is in progress, and `idselOut`, `intDecodeHit` and `masterAbort` are all low.
- R2: A write updates hide bits 7:0 only when `regByteEn[0]` is 1 and bits 15:8 only when `regByteEn[1]` is 1. Each byte lane acts independently, and a write with both enables 0 changes nothing. `regRdData` shows the register in the cycle after the write.
- R3: Bits 7:6 and 15:9 are reserved. They read as 0 whatever is written. Only bits 5:0 and bit 8 hold state.
- R4: A Type 0 cycle to device N (0 to 5) whose hide bit N is 0 drives exactly bit N of `idselOut` (AD[16+N]). `masterAbort` and `intDecodeHit` stay low.
- R5: A Type 0 cycle to device N (0 to 5) whose hide bit N is 1 drives `idselOut` to 0x0000 and raises `masterAbort`.
- R6: A Type 0 cycle to device 8 always drives `idselOut` to 0x0100 (AD[24]), whatever the value of hide bit 8.
- R7: `intDecodeHit` is high only during a Type 0 cycle to device 8 while hide bit 8 is 0. If hide bit 8 is 1, the hit stays low and `masterAbort` rises.
- R8: A Type 0 cycle to any device number other than 0 to 5 and 8 drives no IDSEL bit, leaves `intDecodeHit` low and raises `masterAbort`.
- R9: A Type 1 cycle (`cfgType0` = 0) drives no IDSEL bit, no decode hit and no master abort.
- R10: The hide bits are captured at cycle start. A write during a cycle leaves that cycle's outputs unchanged and applies to the next cycle.
- R11: Outputs are valid from the cycle after `cfgStart` until the cycle after `cfgDone`, and are low otherwise. A `cfgStart` that arrives while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Hide register write strobe |
| regByteEn | input | 2 | Byte-lane enables for the write (bit 0 low byte, bit 1 high byte) |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Hide register read value, reserved bits zero |
| cfgStart | input | 1 | One-cycle pulse that starts a configuration cycle |
| cfgType0 | input | 1 | 1 = Type 0 cycle, 0 = Type 1 cycle |
| cfgDevNum | input | 5 | Target device number |
| cfgDone | input | 1 | One-cycle pulse that ends the configuration cycle |
| cycleBusy | output | 1 | A configuration cycle is in progress |
| idselOut | output | 16 | IDSEL field driven onto AD[31:16] |
| intDecodeHit | output | 1 | Bridge claims the cycle for the integrated device |
| masterAbort | output | 1 | No target claims the Type 0 cycle |

## Verification
The hardest case to reach is a hide-register write that lands inside a configuration cycle. The test opens a cycle to a visible device, writes that device's hide bit while `cycleBusy` is high, and checks that IDSEL is still driven. It then closes the cycle, opens a new one to the same device, and expects IDSEL to be suppressed and a master abort. A second test sends a `cfgStart` with a different device number in mid-cycle and checks that the IDSEL bit that was already selected does not move.

// File: rtl/cfg_idsel_pkg.sv
package cfg_idsel_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cycState_t;

  typedef struct packed {
    logic wrLo;        // write low byte lane of hide register
    logic wrHi;        // write high byte lane of hide register
    logic latchCycle;  // capture device number, type and hide bits
    logic live;        // configuration cycle in progress
  } ctlStrobe_t;

endpackage

// File: rtl/cfg_idsel_ctrl.sv
module cfg_idsel_ctrl
  import cfg_idsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regByteEn,
  input  logic       cfgStart,
  input  logic       cfgDone,
  output ctlStrobe_t strobes
);

  cycState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cfgStart) stateNext = ST_BUSY;
      ST_BUSY: if (cfgDone)  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.wrLo       = regWrEn && regByteEn[0];
    strobes.wrHi       = regWrEn && regByteEn[1];
    strobes.latchCycle = (state == ST_IDLE) && cfgStart;
    strobes.live       = (state == ST_BUSY);
  end

endmodule

// File: rtl/cfg_idsel_dpath.sv
module cfg_idsel_dpath
  import cfg_idsel_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int SEL_W    = 16,
  parameter int DEV_W    = 5,
  parameter int EXT_DEVS = 6,
  parameter int INT_DEV  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobes,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             cfgType0,
  input  logic [DEV_W-1:0] cfgDevNum,
  output logic [SEL_W-1:0] idselOut,
  output logic             intDecodeHit,
  output logic             masterAbort
);

  localparam int HALF = REG_W / 2;

  function automatic logic [REG_W-1:0] liveBits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < EXT_DEVS; i++) m[i] = 1'b1;
    m[INT_DEV] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] LIVE_MASK = liveBits();

  logic [REG_W-1:0]    hideReg;
  logic [EXT_DEVS-1:0] snapExt;
  logic                snapInt;
  logic [DEV_W-1:0]    devQ;
  logic                type0Q;
  logic [SEL_W-1:0]    selBit;
  logic                cycleOn;
  logic                extClaim;

  // Hide register, reserved bits never stored
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hideReg <= '0;
    end else begin
      if (strobes.wrLo) hideReg[HALF-1:0]     <= regWrData[HALF-1:0]     & LIVE_MASK[HALF-1:0];
      if (strobes.wrHi) hideReg[REG_W-1:HALF] <= regWrData[REG_W-1:HALF] & LIVE_MASK[REG_W-1:HALF];
    end
  end

  assign regRdData = hideReg;

  // Per-cycle capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapExt <= '0;
      snapInt <= 1'b0;
      devQ    <= '0;
      type0Q  <= 1'b0;
    end else if (strobes.latchCycle) begin
      snapExt <= hideReg[EXT_DEVS-1:0];
      snapInt <= hideReg[INT_DEV];
      devQ    <= cfgDevNum;
      type0Q  <= cfgType0;
    end
  end

  assign cycleOn = strobes.live && type0Q;

  // One select line per IDSEL bit
  for (genvar g = 0; g < SEL_W; g++) begin : gSel
    if (g < EXT_DEVS) begin : gExt
      assign selBit[g] = (devQ == DEV_W'(g)) && !snapExt[g];
    end else if (g == INT_DEV) begin : gInt
      assign selBit[g] = (devQ == DEV_W'(g));
    end else begin : gNone
      assign selBit[g] = 1'b0;
    end
  end

  assign extClaim     = cycleOn && (|selBit[EXT_DEVS-1:0]);
  assign idselOut     = cycleOn ? selBit : '0;
  assign intDecodeHit = cycleOn && (devQ == DEV_W'(INT_DEV)) && !snapInt;
  assign masterAbort  = cycleOn && !extClaim && !intDecodeHit;

endmodule

// File: rtl/cfg_idsel_gate.sv
module cfg_idsel_gate
  import cfg_idsel_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int SEL_W    = 16,
  parameter int DEV_W    = 5,
  parameter int EXT_DEVS = 6,
  parameter int INT_DEV  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regByteEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             cfgStart,
  input  logic             cfgType0,
  input  logic [DEV_W-1:0] cfgDevNum,
  input  logic             cfgDone,
  output logic             cycleBusy,
  output logic [SEL_W-1:0] idselOut,
  output logic             intDecodeHit,
  output logic             masterAbort
);

  ctlStrobe_t strobes;

  cfg_idsel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regByteEn (regByteEn),
    .cfgStart  (cfgStart),
    .cfgDone   (cfgDone),
    .strobes   (strobes)
  );

  cfg_idsel_dpath #(
    .REG_W(REG_W), .SEL_W(SEL_W), .DEV_W(DEV_W),
    .EXT_DEVS(EXT_DEVS), .INT_DEV(INT_DEV)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .cfgType0     (cfgType0),
    .cfgDevNum    (cfgDevNum),
    .idselOut     (idselOut),
    .intDecodeHit (intDecodeHit),
    .masterAbort  (masterAbort)
  );

  assign cycleBusy = strobes.live;

endmodule

// File: rtl/cfg_idsel_checker.sv
module cfg_idsel_checker #(
  parameter int REG_W    = 16,
  parameter int SEL_W    = 16,
  parameter int EXT_DEVS = 6,
  parameter int INT_DEV  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] regRdData,
  input logic             cycleBusy,
  input logic [SEL_W-1:0] idselOut,
  input logic             intDecodeHit,
  input logic             masterAbort
);

  localparam logic [SEL_W-1:0] EXT_SEL = SEL_W'((1 << EXT_DEVS) - 1);
  localparam logic [REG_W-1:0] RSVD    = ~(REG_W'((1 << EXT_DEVS) - 1) | (REG_W'(1) << INT_DEV));
  localparam logic [SEL_W-1:0] INT_SEL = SEL_W'(1) << INT_DEV;

  AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(idselOut)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & RSVD) == '0); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cycleBusy |-> (idselOut == '0 && !intDecodeHit && !masterAbort)); // R11

  AST_HIT_ON_INT: assert property (@(posedge clk) disable iff (!rstN)
    intDecodeHit |-> idselOut == INT_SEL); // R7

  AST_ABORT_NO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    masterAbort |-> (!intDecodeHit && (idselOut & EXT_SEL) == '0)); // R5

  AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleBusy && $past(cycleBusy)) |-> ($stable(idselOut) && $stable(masterAbort))); // R10

endmodule

bind cfg_idsel_gate cfg_idsel_checker #(
  .REG_W(REG_W), .SEL_W(SEL_W), .EXT_DEVS(EXT_DEVS), .INT_DEV(INT_DEV)
) i_cfg_idsel_checker (
  .clk          (clk),
  .rstN         (rstN),
  .regRdData    (regRdData),
  .cycleBusy    (cycleBusy),
  .idselOut     (idselOut),
  .intDecodeHit (intDecodeHit),
  .masterAbort  (masterAbort)
);

// File: tb/test_cfg_idsel_gate.sv
module test_cfg_idsel_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regByteEn = 2'b00;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        cfgStart = 1'b0;
  logic        cfgType0 = 1'b1;
  logic [4:0]  cfgDevNum = '0;
  logic        cfgDone = 1'b0;
  logic        cycleBusy;
  logic [15:0] idselOut;
  logic        intDecodeHit;
  logic        masterAbort;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_idsel_gate i_cfg_idsel_gate (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .cfgStart(cfgStart), .cfgType0(cfgType0), .cfgDevNum(cfgDevNum), .cfgDone(cfgDone),
    .cycleBusy(cycleBusy), .idselOut(idselOut),
    .intDecodeHit(intDecodeHit), .masterAbort(masterAbort)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic [15:0] sel, input logic hit, input logic abt);
    check(req, "idselOut", idselOut, sel);
    check(req, "intDecodeHit", {15'd0, intDecodeHit}, {15'd0, hit});
    check(req, "masterAbort", {15'd0, masterAbort}, {15'd0, abt});
  endtask

  task automatic regWrite(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regByteEn = be; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = 2'b00;
  endtask

  task automatic startCycle(input logic [4:0] dev, input logic t0);
    @(negedge clk);
    cfgStart = 1'b1; cfgDevNum = dev; cfgType0 = t0;
    @(negedge clk);
    cfgStart = 1'b0;
  endtask

  task automatic endCycle();
    @(negedge clk);
    cfgDone = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "regRdData", regRdData, 16'h0000);
    check("R1", "cycleBusy", {15'd0, cycleBusy}, 16'h0000);
    checkOut("R1", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic tRegAccess();
    regWrite(16'hFFFF, 2'b01);
    check("R3", "low byte, reserved 7:6 zero", regRdData, 16'h003F);
    regWrite(16'hFFFF, 2'b10);
    check("R3", "high byte, reserved 15:9 zero", regRdData, 16'h013F);
    regWrite(16'h0000, 2'b00);
    check("R2", "no byte enable", regRdData, 16'h013F);
    regWrite(16'h0000, 2'b10);
    check("R2", "high lane only", regRdData, 16'h003F);
    regWrite(16'h0000, 2'b11);
    check("R2", "both lanes", regRdData, 16'h0000);
  endtask

  task automatic tVisible();
    for (int d = 0; d < 6; d++) begin
      startCycle(5'(d), 1'b1);
      checkOut("R4", 16'(1 << d), 1'b0, 1'b0);
      check("R11", "busy", {15'd0, cycleBusy}, 16'h0001);
      endCycle();
    end
  endtask

  task automatic tHidden();
    regWrite(16'h0015, 2'b11);
    for (int d = 0; d < 6; d++) begin
      startCycle(5'(d), 1'b1);
      if (d % 2 == 0) checkOut("R5", 16'h0000, 1'b0, 1'b1);
      else            checkOut("R4", 16'(1 << d), 1'b0, 1'b0);
      endCycle();
    end
    regWrite(16'h0000, 2'b11);
  endtask

  task automatic tIntDev();
    startCycle(5'd8, 1'b1);
    checkOut("R6", 16'h0100, 1'b1, 1'b0);
    endCycle();
    startCycle(5'd3, 1'b1);
    checkOut("R7", 16'h0008, 1'b0, 1'b0);
    endCycle();
    regWrite(16'h0100, 2'b10);
    startCycle(5'd8, 1'b1);
    checkOut("R7", 16'h0100, 1'b0, 1'b1);
    endCycle();
    regWrite(16'h0000, 2'b11);
  endtask

  task automatic tUnmapped();
    logic [4:0] devs [4] = '{5'd6, 5'd7, 5'd9, 5'd31};
    for (int i = 0; i < 4; i++) begin
      startCycle(devs[i], 1'b1);
      checkOut("R8", 16'h0000, 1'b0, 1'b1);
      endCycle();
    end
  endtask

  task automatic tType1();
    startCycle(5'd2, 1'b0);
    checkOut("R9", 16'h0000, 1'b0, 1'b0);
    endCycle();
    startCycle(5'd8, 1'b0);
    checkOut("R9", 16'h0000, 1'b0, 1'b0);
    endCycle();
  endtask

  task automatic tSnapshot();
    startCycle(5'd3, 1'b1);
    regWrite(16'h0008, 2'b01);
    check("R10", "reg written mid-cycle", regRdData, 16'h0008);
    checkOut("R10", 16'h0008, 1'b0, 1'b0);
    endCycle();
    startCycle(5'd3, 1'b1);
    checkOut("R10", 16'h0000, 1'b0, 1'b1);
    endCycle();
    regWrite(16'h0000, 2'b11);
  endtask

  task automatic tBusyIgnore();
    startCycle(5'd1, 1'b1);
    startCycle(5'd4, 1'b1);
    checkOut("R11", 16'h0002, 1'b0, 1'b0);
    endCycle();
    check("R11", "busy after done", {15'd0, cycleBusy}, 16'h0000);
    checkOut("R11", 16'h0000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegAccess();
    tVisible();
    tHidden();
    tIntDev();
    tUnmapped();
    tType1();
    tSnapshot();
    tBusyIgnore();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule